// File: doc/BRIEF.md
# Free-Running Periodic Tick Timer

This block is a 12-bit counter that runs continuously from the system clock. It advances only on cycles where a one-microsecond enable tick is high. Two interrupt request lines come from carries out of fixed low-order fields of the count. The fast line fires every 128 ticks, which is 128 µs. The slow line fires every 1024 ticks, which is 1.024 ms. Firmware can read the low byte of the count as the timer data value. The four upper bits stay inside the block.

There is no load, compare or capture logic. The counter wraps without stopping. The interrupt outputs are single-cycle pulses that an interrupt controller can latch.

Top module: `tick_timer`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and in the first cycle after it, `count_lo` is 0 and both `irq_fast` and `irq_slow` are 0.
- R2: On a rising clock edge with `tick` high, the 12-bit count increases by one. With `tick` low, the count holds its value.
- R3: `count_lo` always shows bits 7..0 of the 12-bit count. Bits 11..8 are not visible at any port.
- R4: `irq_fast` is high for exactly the one cycle after a ticked edge that moves the count to a multiple of 128, that is, to a value whose bits 6..0 are all zero.
- R5: `irq_slow` is high for exactly the one cycle after a ticked edge that moves the count to a multiple of 1024, that is, to a value whose bits 9..0 are all zero. Such a cycle also raises `irq_fast`.
- R6: The count wraps from 4095 to 0 and continues counting. The wrapping edge raises both interrupt pulses.
- R7: An edge with `tick` low never raises either interrupt, so no pulse lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle enable pulse at 1 MHz |
| irq_fast | output | 1 | 128-tick interrupt pulse |
| irq_slow | output | 1 | 1024-tick interrupt pulse |
| count_lo | output | 8 | Low byte of the running count |

## Verification
The first pattern is a dense run of back-to-back ticks, longer than one full 4096-count cycle. It shows that pulses land exactly on the 128 and 1024 boundaries and on the wrap. The second pattern is randomly gated ticks at high and at low density. These show whether the counter, and not the clock, paces the interrupts, and whether idle cycles hold the count and emit no pulse. A reset in the middle of the run, followed by another dense run, shows that the counter restarts from zero and that the upper count bits are cleared too: the first slow pulse must come 1024 ticks later.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W    = 12,
  parameter int FAST_TAP = 7,
  parameter int SLOW_TAP = 10,
  parameter int RD_W     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic            irq_fast,
  output logic            irq_slow,
  output logic [RD_W-1:0] count_lo
);

  logic [CNT_W-1:0] cnt;
  logic             carry_fast, carry_slow;

  assign carry_fast = tick && (&cnt[FAST_TAP-1:0]);
  assign carry_slow = tick && (&cnt[SLOW_TAP-1:0]);
  assign count_lo   = cnt[RD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      irq_fast <= 1'b0;
      irq_slow <= 1'b0;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      irq_fast <= carry_fast;
      irq_slow <= carry_slow;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 1'b1);
  p_fast_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> cnt[FAST_TAP-1:0] == '0);
  p_slow_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_slow |-> irq_fast && cnt[SLOW_TAP-1:0] == '0);
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && &cnt) |=> irq_fast && irq_slow && cnt == '0);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !irq_fast && !irq_slow);
  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |=> !irq_fast);

endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       irq_fast, irq_slow;
  logic [7:0] count_lo;

  int checks = 0;
  int failures = 0;
  int exp_cnt = 0;
  bit exp_fast = 0, exp_slow = 0, wrapped = 0, done = 0;

  always #2.5 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .irq_fast(irq_fast), .irq_slow(irq_slow), .count_lo(count_lo)
  );

  function automatic int next_cnt(int c, bit t);
    return t ? (c + 1) % 4096 : c;
  endfunction

  function automatic bit hits(int c, bit t, int period);
    return t && (((c + 1) % period) == 0);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit t);
    tick     = t;
    exp_fast = hits(exp_cnt, t, 128);
    exp_slow = hits(exp_cnt, t, 1024);
    wrapped  = t && exp_cnt == 4095;
    exp_cnt  = next_cnt(exp_cnt, t);
    @(negedge clk);
    check(count_lo == 8'(exp_cnt), "R2/R3 count_lo", count_lo, exp_cnt & 255);
    check(irq_fast == exp_fast, t ? "R4 irq_fast" : "R7 irq_fast idle", irq_fast, exp_fast);
    check(irq_slow == exp_slow, t ? "R5 irq_slow" : "R7 irq_slow idle", irq_slow, exp_slow);
    if (wrapped)
      check(count_lo == 0 && irq_fast && irq_slow, "R6 wrap", count_lo, 0);
  endtask

  task automatic check_reset();
    check(count_lo == 0, "R1 count_lo", count_lo, 0);
    check(!irq_fast && !irq_slow, "R1 irq", {irq_fast, irq_slow}, 0);
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();
    for (int i = 0; i < 4200; i++) step(1'b1);
    for (int i = 0; i < 6000; i++) step(($urandom % 4) != 0);
    for (int i = 0; i < 3000; i++) step(($urandom % 8) == 0);
    rst_n = 1'b0;
    tick  = 1'b0;
    @(negedge clk);
    check_reset();
    rst_n   = 1'b1;
    exp_cnt = 0;
    @(negedge clk);
    check_reset();
    for (int i = 0; i < 1100; i++) step(1'b1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule